// File: doc/BRIEF.md
# Audio Control Register Loader over I2C

This block is a write-only I2C target that fills a small bank of 8-bit control registers for an audio signal path. It samples the SCL and SDA pins with the system clock, finds START and STOP conditions, and compares the first byte of every transfer against one fixed write address. It acknowledges by enabling an open-drain pull-down on SDA. The byte after the address is a subaddress. It names the target register and says whether the register pointer advances after each data byte.

Each data byte after the subaddress is written into the register bank. The bank drives all register contents in parallel. It also raises a one-cycle strobe, carrying the register index and the value, for every byte it stores. At reset the bank returns to a safe state: inputs at maximum attenuation, both speakers muted, surround bypassed, and the first input selected.

Top module: `audio_ctl_i2c_regs`

## Requirements
- R1: START (SDA falls while SCL is high) begins address reception, also in the middle of a transfer. STOP (SDA rises while SCL is high) ends the transfer.
- R2: The write address byte 0x80 (7-bit address 1000000, write direction) is acknowledged by holding `sda_pd_o` high through the ninth SCL pulse. `sda_pd_o` only ever rises while SCL is low.
- R3: Any other address byte, including the read form 0x81, gets no acknowledge. Every byte after it is ignored, with no acknowledge and no register change, until the next START.
- R4: The subaddress byte is acknowledged. Bit 7 enables pointer advance, bits 3:0 give the register index, and bits 6:4 have no effect.
- R5: With bit 7 clear, every data byte before the STOP is written to the same register.
- R6: With bit 7 set, the pointer advances by one after each data byte and wraps from 15 to 0.
- R7: Data bytes aimed at indices 7, 8 or 10 to 15 are acknowledged but are neither stored nor strobed.
- R8: Reset values:
  - index 0 (input attenuation): 0xFF
  - index 1 (surround off, output fixed, effect at -21 dB): 0x7E
  - index 2 (phase): 0x00
  - index 3 (bass flat): 0x1F
  - index 4 (treble flat): 0x7E
  - indices 5 and 6 (speakers muted): 0x78
  - index 9 (input 1): 0x06
  - indices 7 and 8: read as 0x00
- R9: Each stored byte raises `wr_stb_o` for exactly one cycle. In that cycle `wr_idx_o` and `wr_data_o` carry the index and value, and `regs_o` already shows the new value. Without a strobe, `regs_o` holds.
- R10: `sda_pd_o` is released after the ninth SCL pulse and stays low while data bits are being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL pin level |
| sda_i | input | 1 | SDA pin level |
| sda_pd_o | output | 1 | Enable for the open-drain SDA pull-down (acknowledge) |
| wr_stb_o | output | 1 | One-cycle pulse for each stored byte |
| wr_idx_o | output | 4 | Index of the register just stored |
| wr_data_o | output | 8 | Value just stored |
| regs_o | output | NUM_REGS*8 | All registers; index i occupies bits [8i+7:8i] |

## Verification
Two things meet in one cycle here: storing a data byte and starting its acknowledge. The same SCL fall that closes the eighth bit moves the register pointer, queues the write, and raises the pull-down. The bench provokes this with long runs where the pointer advances across the unstorable indices and wraps past 15. Each byte's acknowledge is judged on the bus during the ninth pulse, while a scoreboard compares every strobe against the queued index and value and against the matching `regs_o` slice. Bytes that must not land are judged by the empty queue at the end and by reading back the untouched slices.

// File: rtl/actl_pkg.sv
package actl_pkg;

  localparam int unsigned IDX_W  = 4;
  localparam int unsigned BYTE_W = 8;

  // fixed 7-bit target address, write direction appended as LSB 0
  localparam logic [6:0] TGT_ADDR = 7'b1000000;

  // indices that accept no data
  localparam logic [15:0] NOSTORE_MASK = 16'h0180;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_SUB,
    PH_DATA,
    PH_SKIP
  } rx_phase_e;

  function automatic logic [7:0] reg_default(input int unsigned idx);
    case (idx)
      0:       return 8'hFF;  // input attenuation at maximum
      1:       return 8'h7E;  // surround off, output fixed, effect -21 dB
      2:       return 8'h00;  // phase selection
      3:       return 8'h1F;  // bass flat
      4:       return 8'h7E;  // treble flat
      5, 6:    return 8'h78;  // speaker muted
      9:       return 8'h06;  // input 1 selected
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/actl_line_cond.sv
module actl_line_cond #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_lvl_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);

  logic [STAGES-1:0] scl_q, sda_q;
  logic              scl_d, sda_d;
  logic              scl_lvl;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_q <= '1;
          sda_q <= '1;
        end else begin
          scl_q <= scl_i;
          sda_q <= sda_i;
        end
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_q <= '1;
          sda_q <= '1;
        end else begin
          scl_q <= {scl_q[STAGES-2:0], scl_i};
          sda_q <= {sda_q[STAGES-2:0], sda_i};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_q[STAGES-1];
      sda_d <= sda_q[STAGES-1];
    end
  end

  assign scl_lvl    = scl_q[STAGES-1];
  assign sda_lvl_o  = sda_q[STAGES-1];
  assign scl_rise_o = scl_lvl & ~scl_d;
  assign scl_fall_o = ~scl_lvl & scl_d;
  assign start_o    = scl_lvl & scl_d & sda_d & ~sda_lvl_o;
  assign stop_o     = scl_lvl & scl_d & ~sda_d & sda_lvl_o;

endmodule

// File: rtl/actl_byte_rx.sv
module actl_byte_rx
  import actl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sda_lvl_i,
  input  logic             scl_rise_i,
  input  logic             scl_fall_i,
  input  logic             start_i,
  input  logic             stop_i,
  output logic             sda_pd_o,
  output logic             wr_req_o,
  output logic [IDX_W-1:0] wr_ptr_o,
  output logic [7:0]       wr_byte_o
);

  localparam logic [3:0] LAST_BIT  = 4'(BYTE_W);
  localparam logic [7:0] ADDR_BYTE = {TGT_ADDR, 1'b0};

  rx_phase_e        phase_q, phase_d;
  logic [3:0]       cnt_q, cnt_d;
  logic [7:0]       shreg_q, shreg_d;
  logic             ack_q, ack_d;
  logic             pd_q, pd_d;
  logic [IDX_W-1:0] ptr_q, ptr_d;
  logic             auto_q, auto_d;
  logic             wreq_q, wreq_d;
  logic [IDX_W-1:0] wptr_q, wptr_d;
  logic [7:0]       wbyte_q, wbyte_d;
  logic             receiving;

  assign receiving = (phase_q == PH_ADDR) || (phase_q == PH_SUB) || (phase_q == PH_DATA);

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    shreg_d = shreg_q;
    ack_d   = ack_q;
    pd_d    = pd_q;
    ptr_d   = ptr_q;
    auto_d  = auto_q;
    wreq_d  = 1'b0;
    wptr_d  = wptr_q;
    wbyte_d = wbyte_q;
    if (start_i) begin
      phase_d = PH_ADDR;
      cnt_d   = '0;
      ack_d   = 1'b0;
      pd_d    = 1'b0;
    end else if (stop_i) begin
      phase_d = PH_IDLE;
      cnt_d   = '0;
      ack_d   = 1'b0;
      pd_d    = 1'b0;
    end else if (scl_rise_i && !ack_q && receiving && (cnt_q < LAST_BIT)) begin
      shreg_d = {shreg_q[6:0], sda_lvl_i};
      cnt_d   = cnt_q + 4'd1;
    end else if (scl_fall_i && ack_q) begin
      ack_d = 1'b0;
      pd_d  = 1'b0;
      cnt_d = '0;
    end else if (scl_fall_i && receiving && (cnt_q == LAST_BIT)) begin
      cnt_d = '0;
      unique case (phase_q)
        PH_ADDR: begin
          if (shreg_q == ADDR_BYTE) begin
            ack_d   = 1'b1;
            pd_d    = 1'b1;
            phase_d = PH_SUB;
          end else begin
            phase_d = PH_SKIP;
          end
        end
        PH_SUB: begin
          ptr_d   = shreg_q[IDX_W-1:0];
          auto_d  = shreg_q[7];
          ack_d   = 1'b1;
          pd_d    = 1'b1;
          phase_d = PH_DATA;
        end
        default: begin
          wreq_d  = 1'b1;
          wptr_d  = ptr_q;
          wbyte_d = shreg_q;
          ack_d   = 1'b1;
          pd_d    = 1'b1;
          if (auto_q) ptr_d = ptr_q + 4'd1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      shreg_q <= '0;
      ack_q   <= 1'b0;
      pd_q    <= 1'b0;
      ptr_q   <= '0;
      auto_q  <= 1'b0;
      wreq_q  <= 1'b0;
      wptr_q  <= '0;
      wbyte_q <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      shreg_q <= shreg_d;
      ack_q   <= ack_d;
      pd_q    <= pd_d;
      ptr_q   <= ptr_d;
      auto_q  <= auto_d;
      wreq_q  <= wreq_d;
      wptr_q  <= wptr_d;
      wbyte_q <= wbyte_d;
    end
  end

  assign sda_pd_o  = pd_q;
  assign wr_req_o  = wreq_q;
  assign wr_ptr_o  = wptr_q;
  assign wr_byte_o = wbyte_q;

endmodule

// File: rtl/actl_reg_bank.sv
module actl_reg_bank
  import actl_pkg::*;
#(
  parameter int unsigned NUM_REGS = 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_req_i,
  input  logic [IDX_W-1:0]      wr_ptr_i,
  input  logic [7:0]            wr_byte_i,
  output logic [NUM_REGS*8-1:0] regs_o,
  output logic                  wr_stb_o,
  output logic [IDX_W-1:0]      wr_idx_o,
  output logic [7:0]            wr_data_o
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_REGS - 1);

  logic             storable;
  logic             stb_d;
  logic             stb_q;
  logic [IDX_W-1:0] idx_q;
  logic [7:0]       data_q;

  assign storable = (wr_ptr_i <= LAST_IDX) && !NOSTORE_MASK[wr_ptr_i];
  assign stb_d    = wr_req_i && storable;

  generate
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      if (NOSTORE_MASK[i]) begin : g_hole
        assign regs_o[i*8 +: 8] = 8'h00;
      end else begin : g_store
        logic [7:0] val_q;
        logic       en;
        assign en = stb_d && (wr_ptr_i == IDX_W'(i));
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)  val_q <= reg_default(i);
          else if (en) val_q <= wr_byte_i;
        end
        assign regs_o[i*8 +: 8] = val_q;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q  <= 1'b0;
      idx_q  <= '0;
      data_q <= '0;
    end else begin
      stb_q <= stb_d;
      if (stb_d) begin
        idx_q  <= wr_ptr_i;
        data_q <= wr_byte_i;
      end
    end
  end

  assign wr_stb_o  = stb_q;
  assign wr_idx_o  = idx_q;
  assign wr_data_o = data_q;

endmodule

// File: rtl/audio_ctl_i2c_regs.sv
module audio_ctl_i2c_regs
  import actl_pkg::*;
#(
  parameter int unsigned NUM_REGS    = 10,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_pd_o,
  output logic                  wr_stb_o,
  output logic [3:0]            wr_idx_o,
  output logic [7:0]            wr_data_o,
  output logic [NUM_REGS*8-1:0] regs_o
);

  logic [1:0]       rst_sync_q;
  logic             rst_core_n;
  logic             sda_lvl, scl_rise, scl_fall, start_ev, stop_ev;
  logic             wr_req;
  logic [IDX_W-1:0] wr_ptr;
  logic [7:0]       wr_byte;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  actl_line_cond #(.STAGES(SYNC_STAGES)) line_i (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_lvl_o  (sda_lvl),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_ev),
    .stop_o     (stop_ev)
  );

  actl_byte_rx rx_i (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .sda_lvl_i  (sda_lvl),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start_ev),
    .stop_i     (stop_ev),
    .sda_pd_o   (sda_pd_o),
    .wr_req_o   (wr_req),
    .wr_ptr_o   (wr_ptr),
    .wr_byte_o  (wr_byte)
  );

  actl_reg_bank #(.NUM_REGS(NUM_REGS)) bank_i (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .wr_req_i  (wr_req),
    .wr_ptr_i  (wr_ptr),
    .wr_byte_i (wr_byte),
    .regs_o    (regs_o),
    .wr_stb_o  (wr_stb_o),
    .wr_idx_o  (wr_idx_o),
    .wr_data_o (wr_data_o)
  );

endmodule

// File: rtl/audio_ctl_i2c_regs_chk.sv
module audio_ctl_i2c_regs_chk #(
  parameter int unsigned NUM_REGS = 10
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  scl_i,
  input logic                  sda_pd_o,
  input logic                  wr_stb_o,
  input logic [3:0]            wr_idx_o,
  input logic [7:0]            wr_data_o,
  input logic [NUM_REGS*8-1:0] regs_o
);

  logic [7:0] sel_byte;
  assign sel_byte = 8'(regs_o >> {wr_idx_o, 3'b000});

  AST_STB_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb_o |=> !wr_stb_o);  // R9

  AST_STB_LEGAL_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb_o |-> (int'(wr_idx_o) < NUM_REGS && wr_idx_o != 4'd7 && wr_idx_o != 4'd8));  // R7

  AST_STB_MATCHES_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb_o |-> (sel_byte == wr_data_o));  // R9

  AST_BANK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb_o |-> $stable(regs_o));  // R9

  AST_ACK_RISES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pd_o) |-> !scl_i);  // R2

endmodule

bind audio_ctl_i2c_regs audio_ctl_i2c_regs_chk #(.NUM_REGS(NUM_REGS)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .scl_i     (scl_i),
  .sda_pd_o  (sda_pd_o),
  .wr_stb_o  (wr_stb_o),
  .wr_idx_o  (wr_idx_o),
  .wr_data_o (wr_data_o),
  .regs_o    (regs_o)
);

// File: tb/audio_ctl_i2c_regs_tb_top.sv
module audio_ctl_i2c_regs_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NREG       = 10;
  localparam int Q          = 8;

  logic clk;
  logic rst_n;
  logic scl_drv;
  logic sda_drv;
  logic sda_line;
  logic sda_pd_o;
  logic wr_stb_o;
  logic [3:0] wr_idx_o;
  logic [7:0] wr_data_o;
  logic [NREG*8-1:0] regs_o;

  int n_checks;
  int n_fail;
  logic [11:0] sb_q[$];
  logic prev_stb;

  assign sda_line = sda_drv & ~sda_pd_o;

  audio_ctl_i2c_regs #(.NUM_REGS(NREG)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_drv),
    .sda_i     (sda_line),
    .sda_pd_o  (sda_pd_o),
    .wr_stb_o  (wr_stb_o),
    .wr_idx_o  (wr_idx_o),
    .wr_data_o (wr_data_o),
    .regs_o    (regs_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] exp_default(input int idx);
    case (idx)
      0: return 8'hFF;
      1: return 8'h7E;
      3: return 8'h1F;
      4: return 8'h7E;
      5, 6: return 8'h78;
      9: return 8'h06;
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic report;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_drv = 1'b1; tick(Q);
    scl_drv = 1'b1; tick(Q);
    sda_drv = 1'b0; tick(Q);
    scl_drv = 1'b0; tick(Q);
  endtask

  task automatic bus_stop;
    sda_drv = 1'b0; tick(Q);
    scl_drv = 1'b1; tick(Q);
    sda_drv = 1'b1; tick(Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int nbits);
    for (int i = 7; i > 7 - nbits; i--) begin
      sda_drv = b[i]; tick(Q);
      scl_drv = 1'b1; tick(Q);
      scl_drv = 1'b0; tick(2);
    end
  endtask

  // 8 bits plus the ninth pulse; judges the acknowledge and its release
  task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string req);
    send_bits(b, 8);
    sda_drv = 1'b1; tick(Q);
    scl_drv = 1'b1; tick(Q/2);
    check((!sda_line) == exp_ack, req, "acknowledge", int'(!sda_line), int'(exp_ack));
    tick(Q/2);
    scl_drv = 1'b0; tick(Q);
    check(sda_pd_o == 1'b0, "R10", "pull-down released after ninth pulse", int'(sda_pd_o), 0);
  endtask

  task automatic expect_wr(input int idx, input logic [7:0] d);
    sb_q.push_back({4'(idx), d});
  endtask

  task automatic check_reg(input int idx, input logic [7:0] d, input string req);
    check(regs_o[idx*8 +: 8] == d, req, $sformatf("register %0d", idx),
          int'(regs_o[idx*8 +: 8]), int'(d));
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst_n) begin
      prev_stb <= 1'b0;
    end else begin
      if (prev_stb) check(!wr_stb_o, "R9", "strobe width", int'(wr_stb_o), 0);
      if (wr_stb_o) begin
        if (sb_q.size() == 0) begin
          check(1'b0, "R7", "unexpected strobe index", int'(wr_idx_o), 0);
        end else begin
          logic [11:0] e;
          e = sb_q.pop_front();
          check(wr_idx_o == e[11:8], "R9", "strobe index", int'(wr_idx_o), int'(e[11:8]));
          check(wr_data_o == e[7:0], "R9", "strobe data", int'(wr_data_o), int'(e[7:0]));
          check(regs_o[int'(wr_idx_o)*8 +: 8] == wr_data_o, "R9", "bank shows strobed value",
                int'(regs_o[int'(wr_idx_o)*8 +: 8]), int'(wr_data_o));
        end
      end
      prev_stb <= wr_stb_o;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  initial begin
    n_checks = 0;
    n_fail   = 0;
    rst_n    = 1'b0;
    scl_drv  = 1'b1;
    sda_drv  = 1'b1;
    tick(5);
    rst_n = 1'b1;
    tick(5);

    // R8 reset state
    for (int i = 0; i < NREG; i++) check_reg(i, exp_default(i), "R8");
    check(sda_pd_o == 1'b0, "R10", "pull-down idle", int'(sda_pd_o), 0);
    check(wr_stb_o == 1'b0, "R9", "strobe idle", int'(wr_stb_o), 0);

    // single write to treble (R2, R4)
    bus_start();
    send_byte(8'h80, 1'b1, "R2");
    send_byte(8'h04, 1'b1, "R4");
    expect_wr(4, 8'h5A);
    send_byte(8'h5A, 1'b1, "R5");
    bus_stop();
    check_reg(4, 8'h5A, "R5");

    // fixed pointer, bits 6:4 set and ignored (R4, R5)
    bus_start();
    send_byte(8'h80, 1'b1, "R2");
    send_byte(8'h70, 1'b1, "R4");
    expect_wr(0, 8'h11); send_byte(8'h11, 1'b1, "R5");
    expect_wr(0, 8'h22); send_byte(8'h22, 1'b1, "R5");
    expect_wr(0, 8'h33); send_byte(8'h33, 1'b1, "R5");
    bus_stop();
    check_reg(0, 8'h33, "R5");
    check_reg(1, 8'h7E, "R4");

    // advancing pointer across the holes (R6, R7)
    bus_start();
    send_byte(8'h80, 1'b1, "R2");
    send_byte(8'h85, 1'b1, "R4");
    expect_wr(5, 8'hA1); send_byte(8'hA1, 1'b1, "R6");
    expect_wr(6, 8'hA2); send_byte(8'hA2, 1'b1, "R6");
    send_byte(8'hA3, 1'b1, "R7");
    send_byte(8'hA4, 1'b1, "R7");
    expect_wr(9, 8'hA5); send_byte(8'hA5, 1'b1, "R6");
    send_byte(8'hA6, 1'b1, "R7");
    bus_stop();
    check_reg(7, 8'h00, "R7");
    check_reg(8, 8'h00, "R7");
    check_reg(9, 8'hA5, "R6");

    // wrap from 15 to 0 (R6)
    bus_start();
    send_byte(8'h80, 1'b1, "R2");
    send_byte(8'h8E, 1'b1, "R4");
    send_byte(8'hB1, 1'b1, "R7");
    send_byte(8'hB2, 1'b1, "R7");
    expect_wr(0, 8'hB3); send_byte(8'hB3, 1'b1, "R6");
    expect_wr(1, 8'hB4); send_byte(8'hB4, 1'b1, "R6");
    bus_stop();
    check_reg(0, 8'hB3, "R6");
    check_reg(1, 8'hB4, "R6");

    // fixed pointer on a hole and beyond the bank (R7)
    bus_start();
    send_byte(8'h80, 1'b1, "R2");
    send_byte(8'h07, 1'b1, "R4");
    send_byte(8'hC1, 1'b1, "R7");
    bus_stop();
    bus_start();
    send_byte(8'h80, 1'b1, "R2");
    send_byte(8'h0C, 1'b1, "R4");
    send_byte(8'hC2, 1'b1, "R7");
    bus_stop();
    check_reg(7, 8'h00, "R7");

    // wrong address and read direction (R3)
    bus_start();
    send_byte(8'h82, 1'b0, "R3");
    send_byte(8'h01, 1'b0, "R3");
    send_byte(8'h99, 1'b0, "R3");
    bus_stop();
    bus_start();
    send_byte(8'h81, 1'b0, "R3");
    send_byte(8'h01, 1'b0, "R3");
    send_byte(8'h55, 1'b0, "R3");
    bus_stop();
    check_reg(1, 8'hB4, "R3");

    // repeated START after subaddress and in mid-byte (R1)
    bus_start();
    send_byte(8'h80, 1'b1, "R2");
    send_byte(8'h02, 1'b1, "R4");
    bus_start();
    send_byte(8'h80, 1'b1, "R1");
    send_byte(8'h86, 1'b1, "R1");
    send_bits(8'hEE, 3);
    bus_start();
    send_byte(8'h80, 1'b1, "R1");
    send_byte(8'h03, 1'b1, "R1");
    expect_wr(3, 8'hD1); send_byte(8'hD1, 1'b1, "R1");
    bus_stop();
    check_reg(2, 8'h00, "R1");
    check_reg(3, 8'hD1, "R1");
    check_reg(6, 8'hA2, "R1");

    // after STOP, data-shaped bytes are not taken as data (R1)
    send_byte(8'h44, 1'b0, "R1");
    bus_stop();
    check_reg(3, 8'hD1, "R1");

    tick(20);
    check(sb_q.size() == 0, "R9", "scoreboard drained", sb_q.size(), 0);
    report();
    $finish;
  end

endmodule